// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block holds the 64-byte standard configuration header of a single-function PCI endpoint. The header is organised as sixteen 32-bit dwords. A host-side agent reaches it through a dword-indexed port with per-byte write enables. Reads are registered, so the data for an index appears one clock after the index is presented. Identity and capability fields are fixed by parameters. Control fields are writable storage. Error flags are raised by one-cycle event pulses from the device logic and are cleared by software writing ones to them.

The block decodes five command bits into enable outputs for the rest of the device: I/O decode, memory decode, bus mastering, parity response and system-error signalling. It also runs the built-in self-test handshake. Software sets a start bit, which raises a run output. The run ends when the device reports completion or when a cycle-count timeout expires. The block then latches the result nibble, or a failure code if the timeout ended the run.

Top module: `pci_cfg_space`

## Requirements
- R1: Index 0 reads {DEVICE_ID, VENDOR_ID}. Index 2 reads {CLASS_CODE[23:0], REVISION[7:0]}. Both come from parameters, and writes to them have no effect.
- R2: `cfg_rdata` is registered. It shows the dword for the index presented at a rising edge from that edge onwards, and it keeps its previous value until that edge.
- R3: Command bits 9:0 sit in `cfg_wdata` bits 9:0 of index 1. They are written only where `cfg_be[0]` (bits 7:0) and `cfg_be[1]` (bits 9:8) are high. Command bits 15:10 always read as zero.
- R4: `en_io`, `en_mem`, `en_master`, `en_par_resp` and `en_serr` follow command bits 0, 1, 2, 6 and 8. They change only after a write to index 1.
- R5: A one-cycle pulse sets one status flag. The flags sit in index 1 at these bits: detected parity 31, signalled system error 30, received master abort 29, received target abort 28, signalled target abort 27, data parity reported 24.
- R6: Writing 1 to a flag position with `cfg_be[3]` high clears that flag. Writing 0 leaves the flag unchanged. If a set pulse and a clearing write arrive in the same cycle, the flag stays set.
- R7: Index 1 bits 26:25 read DEVSEL_SPEED, which is never 2'b11. Bit 23 reads FAST_B2B_CAP, bit 22 reads UDF_CAP and bit 21 reads CAP_66MHZ. Writes have no effect on these bits.
- R8: In index 3, byte 0 (cache line size) and byte 1 (latency timer) are read/write. Byte 2 (header type) always reads 8'h00.
- R9: Index 3 bit 31 reads 1, marking the self-test as capable. Writing 1 to bit 30 with `cfg_be[3]` high sets the start bit and `bist_go`. A `bist_done` pulse clears both and latches `bist_result` into bits 27:24. Writing 0 to bit 30 does not stop a run.
- R10: If no `bist_done` arrives, `bist_go` stays high for exactly BIST_TIMEOUT cycles. It then clears, and the return code reads 4'hF.
- R11: In index 15, byte 0 (interrupt line) is read/write and drives no output. Byte 1 reads 8'h01, for the first interrupt pin. Byte 2 reads MIN_GRANT and byte 3 reads MAX_LATENCY.
- R12: Indexes 4 through 14 read as zero and ignore writes.
- R13: After reset, the command bits, the flags, the cache line size, the latency timer, the interrupt line, the return code and `bist_go` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 4 | Dword index (byte offset / 4) |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| ev_par_det | input | 1 | Parity error detected pulse |
| ev_serr_sent | input | 1 | System error driven pulse |
| ev_mabort_rcvd | input | 1 | Master abort received pulse |
| ev_tabort_rcvd | input | 1 | Target abort received pulse |
| ev_tabort_sent | input | 1 | Target abort signalled pulse |
| ev_dpar_rep | input | 1 | Data parity reported pulse |
| bist_done | input | 1 | Self-test completion pulse |
| bist_result | input | 4 | Self-test result, sampled with bist_done |
| bist_go | output | 1 | Self-test running |
| en_io | output | 1 | I/O decode enable |
| en_mem | output | 1 | Memory decode enable |
| en_master | output | 1 | Bus master enable |
| en_par_resp | output | 1 | Parity error response enable |
| en_serr | output | 1 | System error signalling enable |

## Verification
The bench uses distinctive identity values and DEVSEL_SPEED of 2'b01, so a swapped field or a misplaced status bit shows up in the readback. It sets FAST_B2B_CAP and CAP_66MHZ and leaves UDF_CAP clear, so a one in bit 22 would be wrong. BIST_TIMEOUT is set to 20 instead of a two-second cycle count. This lets the bench count the exact length of the run window and read the failure code within a short run.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int IDX_W = 4;
    localparam int DW    = 32;

    localparam logic [IDX_W-1:0] IX_IDENT   = 4'd0;
    localparam logic [IDX_W-1:0] IX_CMDSTAT = 4'd1;
    localparam logic [IDX_W-1:0] IX_CLASS   = 4'd2;
    localparam logic [IDX_W-1:0] IX_TIMING  = 4'd3;
    localparam logic [IDX_W-1:0] IX_INTR    = 4'd15;

    localparam logic [3:0] BIST_FAIL_CODE = 4'hF;

    typedef struct packed {
        logic par_det;
        logic serr_sent;
        logic mabort_rcvd;
        logic tabort_rcvd;
        logic tabort_sent;
        logic dpar_rep;
    } err_flags_t;

    typedef struct packed {
        logic       b2b_en;
        logic       serr_en;
        logic       step_en;
        logic       par_resp;
        logic       pal_snoop;
        logic       mwi_en;
        logic       spc_en;
        logic       master;
        logic       mem;
        logic       io;
    } cmd_bits_t;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [3:0]        be;
        logic [DW-1:0]     data;
    } wr_req_t;

    function automatic logic [15:0] status_word(
        input err_flags_t f,
        input logic [1:0] devsel,
        input logic       fbb,
        input logic       udf,
        input logic       m66
    );
        logic [15:0] s;
        s       = '0;
        s[15]   = f.par_det;
        s[14]   = f.serr_sent;
        s[13]   = f.mabort_rcvd;
        s[12]   = f.tabort_rcvd;
        s[11]   = f.tabort_sent;
        s[10:9] = devsel;
        s[8]    = f.dpar_rep;
        s[7]    = fbb;
        s[6]    = udf;
        s[5]    = m66;
        return s;
    endfunction

    function automatic err_flags_t clear_mask(input wr_req_t w);
        err_flags_t m;
        m = '0;
        if (w.we && w.idx == IX_CMDSTAT && w.be[3]) begin
            m.par_det     = w.data[31];
            m.serr_sent   = w.data[30];
            m.mabort_rcvd = w.data[29];
            m.tabort_rcvd = w.data[28];
            m.tabort_sent = w.data[27];
            m.dpar_rep    = w.data[24];
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_cmd_stat.sv
module cfg_cmd_stat
    import cfg_hdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    input  err_flags_t events,
    output cmd_bits_t  cmd,
    output err_flags_t flags
);
    logic hit;
    assign hit = wr.we && (wr.idx == IX_CMDSTAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (hit) begin
            if (wr.be[0]) cmd[7:0] <= wr.data[7:0];
            if (wr.be[1]) cmd[9:8] <= wr.data[9:8];
        end
    end

    err_flags_t clr;
    assign clr = clear_mask(wr);

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | events;
    end
endmodule

// File: rtl/cfg_bist_seq.sv
module cfg_bist_seq #(
    parameter bit BIST_CAPABLE = 1'b1,
    parameter int BIST_TIMEOUT = 66_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       done,
    input  logic [3:0] result,
    output logic       running,
    output logic [3:0] code
);
    localparam int TW = $clog2(BIST_TIMEOUT + 1);
    localparam logic [TW-1:0] LAST = TW'(BIST_TIMEOUT - 1);

    generate
        if (BIST_CAPABLE) begin : g_bist
            logic [TW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    running <= 1'b0;
                    code    <= '0;
                    cnt     <= '0;
                end else if (!running) begin
                    if (start_req) begin
                        running <= 1'b1;
                        cnt     <= '0;
                    end
                end else if (done) begin
                    running <= 1'b0;
                    code    <= result;
                end else if (cnt == LAST) begin
                    running <= 1'b0;
                    code    <= cfg_hdr_pkg::BIST_FAIL_CODE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else begin : g_nobist
            assign running = 1'b0;
            assign code    = 4'h0;
        end
    endgenerate
endmodule

// File: rtl/cfg_misc_regs.sv
module cfg_misc_regs
    import cfg_hdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    output logic [7:0] cache_line,
    output logic [7:0] lat_timer,
    output logic [7:0] irq_line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cache_line <= '0;
            lat_timer  <= '0;
            irq_line   <= '0;
        end else if (wr.we) begin
            if (wr.idx == IX_TIMING) begin
                if (wr.be[0]) cache_line <= wr.data[7:0];
                if (wr.be[1]) lat_timer  <= wr.data[15:8];
            end
            if (wr.idx == IX_INTR && wr.be[0]) irq_line <= wr.data[7:0];
        end
    end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h0000,
    parameter logic [15:0] DEVICE_ID    = 16'h0000,
    parameter logic [7:0]  REVISION     = 8'h00,
    parameter logic [23:0] CLASS_CODE   = 24'h000000,
    parameter logic [1:0]  DEVSEL_SPEED = 2'b00,
    parameter bit          FAST_B2B_CAP = 1'b0,
    parameter bit          UDF_CAP      = 1'b0,
    parameter bit          CAP_66MHZ    = 1'b0,
    parameter bit          BIST_CAPABLE = 1'b1,
    parameter logic [7:0]  MIN_GRANT    = 8'h00,
    parameter logic [7:0]  MAX_LATENCY  = 8'h00
) (
    input  logic [IDX_W-1:0] idx,
    input  cmd_bits_t        cmd,
    input  err_flags_t       flags,
    input  logic [7:0]       cache_line,
    input  logic [7:0]       lat_timer,
    input  logic [7:0]       irq_line,
    input  logic             bist_run,
    input  logic [3:0]       bist_code,
    output logic [DW-1:0]    dword
);
    localparam logic [7:0] HDR_TYPE = 8'h00;
    localparam logic [7:0] IRQ_PIN  = 8'h01;

    logic [7:0] bist_byte;
    assign bist_byte = {BIST_CAPABLE, bist_run, 2'b00, bist_code};

    always_comb begin
        dword = '0;
        unique case (idx)
            IX_IDENT:   dword = {DEVICE_ID, VENDOR_ID};
            IX_CMDSTAT: dword = {status_word(flags, DEVSEL_SPEED, FAST_B2B_CAP,
                                             UDF_CAP, CAP_66MHZ),
                                 6'b000000, cmd};
            IX_CLASS:   dword = {CLASS_CODE, REVISION};
            IX_TIMING:  dword = {bist_byte, HDR_TYPE, lat_timer, cache_line};
            IX_INTR:    dword = {MAX_LATENCY, MIN_GRANT, IRQ_PIN, irq_line};
            default:    dword = '0;
        endcase
    end
endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h1234,
    parameter logic [15:0] DEVICE_ID    = 16'h5678,
    parameter logic [7:0]  REVISION     = 8'h01,
    parameter logic [23:0] CLASS_CODE   = 24'hFF0000,
    parameter logic [1:0]  DEVSEL_SPEED = 2'b00,
    parameter bit          FAST_B2B_CAP = 1'b0,
    parameter bit          UDF_CAP      = 1'b0,
    parameter bit          CAP_66MHZ    = 1'b0,
    parameter bit          BIST_CAPABLE = 1'b1,
    parameter int          BIST_TIMEOUT = 66_000_000,
    parameter logic [7:0]  MIN_GRANT    = 8'h00,
    parameter logic [7:0]  MAX_LATENCY  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  cfg_idx,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        ev_par_det,
    input  logic        ev_serr_sent,
    input  logic        ev_mabort_rcvd,
    input  logic        ev_tabort_rcvd,
    input  logic        ev_tabort_sent,
    input  logic        ev_dpar_rep,
    input  logic        bist_done,
    input  logic [3:0]  bist_result,
    output logic        bist_go,
    output logic        en_io,
    output logic        en_mem,
    output logic        en_master,
    output logic        en_par_resp,
    output logic        en_serr
);
    wr_req_t    wr;
    err_flags_t events;
    cmd_bits_t  cmd;
    err_flags_t flags;
    logic [7:0] cache_line, lat_timer, irq_line;
    logic [3:0] bist_code;
    logic [DW-1:0] rd_next;
    logic       start_req;

    assign wr = '{we: cfg_wr, idx: cfg_idx, be: cfg_be, data: cfg_wdata};

    assign events = '{par_det: ev_par_det, serr_sent: ev_serr_sent,
                      mabort_rcvd: ev_mabort_rcvd, tabort_rcvd: ev_tabort_rcvd,
                      tabort_sent: ev_tabort_sent, dpar_rep: ev_dpar_rep};

    assign start_req = cfg_wr && (cfg_idx == IX_TIMING) && cfg_be[3] && cfg_wdata[30];

    cfg_cmd_stat u_cmd_stat (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .events (events),
        .cmd    (cmd),
        .flags  (flags)
    );

    cfg_bist_seq #(
        .BIST_CAPABLE (BIST_CAPABLE),
        .BIST_TIMEOUT (BIST_TIMEOUT)
    ) u_bist (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .done      (bist_done),
        .result    (bist_result),
        .running   (bist_go),
        .code      (bist_code)
    );

    cfg_misc_regs u_misc (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .cache_line (cache_line),
        .lat_timer  (lat_timer),
        .irq_line   (irq_line)
    );

    cfg_rd_mux #(
        .VENDOR_ID    (VENDOR_ID),
        .DEVICE_ID    (DEVICE_ID),
        .REVISION     (REVISION),
        .CLASS_CODE   (CLASS_CODE),
        .DEVSEL_SPEED (DEVSEL_SPEED),
        .FAST_B2B_CAP (FAST_B2B_CAP),
        .UDF_CAP      (UDF_CAP),
        .CAP_66MHZ    (CAP_66MHZ),
        .BIST_CAPABLE (BIST_CAPABLE),
        .MIN_GRANT    (MIN_GRANT),
        .MAX_LATENCY  (MAX_LATENCY)
    ) u_rd_mux (
        .idx        (cfg_idx),
        .cmd        (cmd),
        .flags      (flags),
        .cache_line (cache_line),
        .lat_timer  (lat_timer),
        .irq_line   (irq_line),
        .bist_run   (bist_go),
        .bist_code  (bist_code),
        .dword      (rd_next)
    );

    always_ff @(posedge clk) begin
        if (rst) cfg_rdata <= '0;
        else     cfg_rdata <= rd_next;
    end

    assign en_io       = cmd.io;
    assign en_mem      = cmd.mem;
    assign en_master   = cmd.master;
    assign en_par_resp = cmd.par_resp;
    assign en_serr     = cmd.serr_en;

    initial begin
        if (DEVSEL_SPEED == 2'b11)
            $error("DEVSEL_SPEED 2'b11 is reserved");
    end
endmodule

// File: rtl/pci_cfg_space_chk.sv
module pci_cfg_space_chk #(
    parameter int         BIST_TIMEOUT = 20,
    parameter logic [1:0] DEVSEL_SPEED = 2'b00
) (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  cfg_idx,
    input logic        cfg_wr,
    input logic [31:0] cfg_rdata,
    input logic        ev_par_det,
    input logic        bist_go,
    input logic        bist_done,
    input logic        en_io,
    input logic        en_mem,
    input logic        en_master,
    input logic        en_par_resp,
    input logic        en_serr
);
    logic [31:0] run_len;
    always_ff @(posedge clk) begin
        if (rst || !bist_go) run_len <= '0;
        else                 run_len <= run_len + 1;
    end

    assert_cmd_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_idx) == 4'd1 && !$past(rst)) |-> cfg_rdata[15:10] == 6'd0);

    assert_enable_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && cfg_idx == 4'd1) |=>
            $stable({en_io, en_mem, en_master, en_par_resp, en_serr}));

    assert_pardet_sets_R5: assert property (@(posedge clk) disable iff (rst)
        ev_par_det ##1 (cfg_idx == 4'd1) |=> cfg_rdata[31]);

    assert_devsel_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_idx) == 4'd1 && !$past(rst)) |-> cfg_rdata[26:25] == DEVSEL_SPEED);

    assert_bist_done_ends_R9: assert property (@(posedge clk) disable iff (rst)
        (bist_go && bist_done) |=> !bist_go);

    assert_bist_window_R10: assert property (@(posedge clk) disable iff (rst)
        bist_go |-> run_len < BIST_TIMEOUT);

    assert_irq_pin_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_idx) == 4'd15 && !$past(rst)) |-> cfg_rdata[15:8] == 8'h01);

    assert_unimpl_zero_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_idx) >= 4'd4 && $past(cfg_idx) <= 4'd14 && !$past(rst))
            |-> cfg_rdata == 32'h0);
endmodule

bind pci_cfg_space pci_cfg_space_chk #(
    .BIST_TIMEOUT (BIST_TIMEOUT),
    .DEVSEL_SPEED (DEVSEL_SPEED)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_idx     (cfg_idx),
    .cfg_wr      (cfg_wr),
    .cfg_rdata   (cfg_rdata),
    .ev_par_det  (ev_par_det),
    .bist_go     (bist_go),
    .bist_done   (bist_done),
    .en_io       (en_io),
    .en_mem      (en_mem),
    .en_master   (en_master),
    .en_par_resp (en_par_resp),
    .en_serr     (en_serr)
);

// File: tb/test_pci_cfg_space.sv
`timescale 1ns/1ps
module test_pci_cfg_space;
    localparam int T_TO = 20;
    localparam logic [31:0] ID_DW    = 32'h3C4D_1A2B;
    localparam logic [31:0] CLASS_DW = 32'h0280_0007;
    localparam logic [15:0] STAT_FIX = 16'h02A0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic ev_par_det = 0, ev_serr_sent = 0, ev_mabort_rcvd = 0;
    logic ev_tabort_rcvd = 0, ev_tabort_sent = 0, ev_dpar_rep = 0;
    logic        bist_done = 1'b0;
    logic [3:0]  bist_result = '0;
    logic bist_go, en_io, en_mem, en_master, en_par_resp, en_serr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pci_cfg_space #(
        .VENDOR_ID (16'h1A2B), .DEVICE_ID (16'h3C4D), .REVISION (8'h07),
        .CLASS_CODE (24'h028000), .DEVSEL_SPEED (2'b01), .FAST_B2B_CAP (1'b1),
        .UDF_CAP (1'b0), .CAP_66MHZ (1'b1), .BIST_CAPABLE (1'b1),
        .BIST_TIMEOUT (T_TO), .MIN_GRANT (8'h10), .MAX_LATENCY (8'h20)
    ) i_pci_cfg_space (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_dw(input logic [3:0] idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_idx = idx; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd_dw(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        cfg_idx = idx;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd_dw(4'd1, d);  check("R13 cmd/status", d, {STAT_FIX, 16'h0000});
        rd_dw(4'd3, d);  check("R13 timing dword", d, 32'h8000_0000);
        rd_dw(4'd15, d); check("R13 intr dword", d, 32'h2010_0100);
        check("R13 bist_go", {31'd0, bist_go}, 32'd0);
        check("R13 enables", {27'd0, en_io, en_mem, en_master, en_par_resp, en_serr}, 32'd0);
    endtask

    task automatic t_identity;
        logic [31:0] d;
        wr_dw(4'd0, 32'hFFFF_FFFF, 4'hF);
        wr_dw(4'd2, 32'h0, 4'hF);
        rd_dw(4'd0, d); check("R1 ident", d, ID_DW);
        rd_dw(4'd2, d); check("R1 class", d, CLASS_DW);
    endtask

    task automatic t_latency;
        @(negedge clk); cfg_idx = 4'd2;
        @(negedge clk); cfg_idx = 4'd0;
        #1 check("R2 before edge", cfg_rdata, CLASS_DW);
        @(negedge clk); check("R2 after edge", cfg_rdata, ID_DW);
    endtask

    task automatic t_command;
        logic [31:0] d;
        wr_dw(4'd1, 32'h0000_0347, 4'b0011);
        rd_dw(4'd1, d); check("R3 cmd write", {16'd0, d[15:0]}, 32'h0347);
        check("R4 enables on", {27'd0, en_io, en_mem, en_master, en_par_resp, en_serr}, 32'h1F);
        wr_dw(4'd1, 32'h0000_FFFF, 4'b0011);
        rd_dw(4'd1, d); check("R3 reserved zero", {16'd0, d[15:0]}, 32'h03FF);
        wr_dw(4'd1, 32'h0000_0000, 4'b0001);
        rd_dw(4'd1, d); check("R3 byte enable", {16'd0, d[15:0]}, 32'h0300);
        check("R4 enables partial", {27'd0, en_io, en_mem, en_master, en_par_resp, en_serr}, 32'h01);
        wr_dw(4'd1, 32'hFFFF_0000, 4'b1100);
        rd_dw(4'd1, d); check("R7 fixed status bits", {16'd0, d[31:16]}, {16'd0, STAT_FIX});
    endtask

    task automatic t_status;
        logic [31:0] d;
        @(negedge clk);
        ev_par_det = 1; ev_serr_sent = 1; ev_mabort_rcvd = 1;
        ev_tabort_rcvd = 1; ev_tabort_sent = 1; ev_dpar_rep = 1;
        @(negedge clk);
        ev_par_det = 0; ev_serr_sent = 0; ev_mabort_rcvd = 0;
        ev_tabort_rcvd = 0; ev_tabort_sent = 0; ev_dpar_rep = 0;
        rd_dw(4'd1, d); check("R5 all flags set", {16'd0, d[31:16]}, {16'd0, STAT_FIX | 16'hF900});
        wr_dw(4'd1, 32'h0000_0000, 4'b1000);
        rd_dw(4'd1, d); check("R6 write zero keeps", {16'd0, d[31:16]}, {16'd0, STAT_FIX | 16'hF900});
        wr_dw(4'd1, 32'hA100_0000, 4'b1000);
        rd_dw(4'd1, d); check("R6 w1c partial", {16'd0, d[31:16]}, {16'd0, STAT_FIX | 16'h5800});
        wr_dw(4'd1, 32'hFF00_0000, 4'b0100);
        rd_dw(4'd1, d); check("R6 needs byte 3", {16'd0, d[31:16]}, {16'd0, STAT_FIX | 16'h5800});
        @(negedge clk);
        ev_mabort_rcvd = 1; cfg_idx = 4'd1; cfg_wdata = 32'hFF00_0000; cfg_be = 4'b1000; cfg_wr = 1;
        @(negedge clk);
        ev_mabort_rcvd = 0; cfg_wr = 0; cfg_be = 0;
        rd_dw(4'd1, d); check("R6 set wins", {16'd0, d[31:16]}, {16'd0, STAT_FIX | 16'h2000});
        wr_dw(4'd1, 32'hFF00_0000, 4'b1000);
        rd_dw(4'd1, d); check("R5 cleared", {16'd0, d[31:16]}, {16'd0, STAT_FIX});
    endtask

    task automatic t_timing_regs;
        logic [31:0] d;
        wr_dw(4'd3, 32'h00FF_4020, 4'b0111);
        rd_dw(4'd3, d); check("R8 cache/latency/header", d, 32'h8000_4020);
        wr_dw(4'd15, 32'hFFFF_FF0B, 4'hF);
        rd_dw(4'd15, d); check("R11 intr dword", d, 32'h2010_010B);
    endtask

    task automatic t_bist_done;
        logic [31:0] d;
        wr_dw(4'd3, 32'h4000_0000, 4'b1000);
        check("R9 go after start", {31'd0, bist_go}, 32'd1);
        rd_dw(4'd3, d); check("R9 start bit", {24'd0, d[31:24]}, 32'hC0);
        wr_dw(4'd3, 32'h0000_0000, 4'b1000);
        check("R9 zero write keeps run", {31'd0, bist_go}, 32'd1);
        @(negedge clk); bist_done = 1; bist_result = 4'h5;
        @(negedge clk); bist_done = 0; bist_result = 0;
        check("R9 done clears go", {31'd0, bist_go}, 32'd0);
        rd_dw(4'd3, d); check("R9 result latched", {24'd0, d[31:24]}, 32'h85);
    endtask

    task automatic t_bist_timeout;
        logic [31:0] d;
        int hi;
        hi = 0;
        wr_dw(4'd3, 32'h4000_0000, 4'b1000);
        for (int k = 0; k < T_TO + 10; k++) begin
            if (bist_go) hi++;
            @(negedge clk);
        end
        check("R10 window length", hi, T_TO);
        rd_dw(4'd3, d); check("R10 fail code", {24'd0, d[31:24]}, 32'h8F);
        wr_dw(4'd3, 32'h4000_0000, 4'b1000);
        repeat (2) @(negedge clk);
        bist_done = 1; bist_result = 4'h0;
        @(negedge clk); bist_done = 0;
        rd_dw(4'd3, d); check("R9 pass code", {24'd0, d[31:24]}, 32'h80);
    endtask

    task automatic t_unimpl;
        logic [31:0] d;
        for (int i = 4; i <= 14; i++) begin
            wr_dw(i[3:0], 32'hDEAD_BEEF, 4'hF);
            rd_dw(i[3:0], d); check("R12 unimplemented", d, 32'h0);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_identity();
        t_latency();
        t_command();
        t_status();
        t_timing_regs();
        t_bist_done();
        t_bist_timeout();
        t_unimpl();
        repeat (3) @(negedge clk);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule